// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial-audio bit clock and frame clock for a host-side (master) audio port. It runs on the system clock and counts master-clock ticks, which arrive as a one-cycle enable `mclk_en`. A programmable integer prescaler turns those ticks into bit periods. A bit counter then groups the bit periods into frames whose length comes from the slot count and the slot width.

Besides the two clock levels for the pads, the block gives the serializers single-cycle strobes. One strobe marks each bit-clock rising edge and one marks each falling edge, both taken before output inversion. A frame-start strobe coincides with the falling edge that opens bit 0 of slot 0.

The configuration is copied into shadow registers in every cycle while `enable` is low and is held while `enable` is high. Raising `enable` restarts the bit and frame counters from a known point.

Top module: `aclk_gen`

## Requirements
- R1: While reset is held, and while idle afterwards with the configuration at zero, `bclk` is 0, `fclk` is 1, and all three strobes are 0.
- R2: With a divide value n of 2 or more, a bit period lasts n master ticks. `bclk_fall` opens the period. `bclk_rise` follows ceil(n/2) ticks later, so the high phase is floor(n/2) ticks. Each strobe appears in the cycle after the tick that causes it, and at that point `bclk` already shows the new level.
- R3: With a divide value of 1, every master tick produces both `bclk_fall` and `bclk_rise` in the following cycle, and the internal bit clock is high in that cycle.
- R4: With a divide value of 0, no strobe is produced and `bclk` stays at its inactive level, which is the value of the bit-clock invert bit.
- R5: Only cycles with `mclk_en` high advance the prescaler.
- R6: The frame is S × W bit periods long. S is 2 when `tdm_cfg` is 0. Otherwise S is `chans_cfg` with bit 0 ignored, clamped to the range 2..16.
- R7: The slot width W is 16 only when `wide_slot_cfg` is 0 and `dsize_cfg` is 0 (the 16-bit code). Every other `dsize_cfg` code (1 = 24-bit, 2 = 32-bit) forces W to 32.
- R8: `fclk` changes only on bit-clock falling edges. It changes at the fall that opens bit 0 of a frame, where `frame_start` pulses in the same cycle as `bclk_fall`, and again at the fall that opens bit S×W/2.
- R9: With `rise_edge_cfg` 0, `fclk` falls at frame start. With 1, it rises. `inv_fclk_cfg` inverts `fclk` further, and `inv_bclk_cfg` inverts `bclk`.
- R10: While `gate_off` is high, `bclk` sits at its inactive level, no strobes appear and the counters hold. Counting resumes when `gate_off` falls.
- R11: Configuration inputs, apart from `gate_off`, that change while `enable` is high have no effect until `enable` has been low for a cycle.
- R12: The first master tick after `enable` rises produces `bclk_fall` together with `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_en | input | 1 | One-cycle master-clock tick |
| enable | input | 1 | Run enable; configuration is captured while low |
| gate_off | input | 1 | Live gate; holds the bit clock inactive |
| div_cfg | input | 9 | Prescaler divide value (0 = stopped) |
| inv_bclk_cfg | input | 1 | Invert the bit clock output |
| inv_fclk_cfg | input | 1 | Invert the frame clock output |
| rise_edge_cfg | input | 1 | 1: rising frame-clock edge starts a frame |
| tdm_cfg | input | 1 | Multi-slot mode |
| chans_cfg | input | 5 | Slot count in multi-slot mode |
| wide_slot_cfg | input | 1 | Select 32-bit slots when data size is 16 |
| dsize_cfg | input | 2 | Sample size code: 0 = 16, 1 = 24, 2 = 32 |
| bclk | output | 1 | Bit-clock level |
| bclk_rise | output | 1 | Internal bit-clock rising strobe |
| bclk_fall | output | 1 | Internal bit-clock falling strobe |
| fclk | output | 1 | Frame-clock level |
| frame_start | output | 1 | Strobe on the fall that opens bit 0 of slot 0 |

## Verification
The hardest situation to reach from the ports is a live change of the divide value and the frame-clock invert bit in the middle of a long multi-slot frame. There, only the absence of any change in edge timing and frame-clock level shows that the shadow copy held. The scoreboard reaches it by queueing the full edge schedule from the configuration captured at enable time, and then driving different values onto the configuration pins partway through the run. A second case combines an odd divide value with a master tick on only every third cycle. In that case, an error of one tick in the phase split or in tick qualification moves every later edge.

// File: rtl/aclk_pkg.sv
// Shared constants, the shadow-configuration record and the frame-length rule.
package aclk_pkg;
    localparam int DIV_W    = 9;
    localparam int CH_W     = 5;
    localparam int MAX_CH   = 16;
    localparam int SLOT_MAX = 32;
    localparam int FCNT_W   = $clog2(MAX_CH * SLOT_MAX);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              inv_b;
        logic              inv_f;
        logic              rise_edge;
        logic [FCNT_W-1:0] flast;
        logic [FCNT_W-1:0] half;
    } shadow_t;

    // Number of bit periods in one frame: slot count times slot width.
    function automatic int frame_bits(input logic tdm, input logic [CH_W-1:0] ch,
                                      input logic wide, input logic [1:0] dsize);
        int slots;
        int width;
        slots = tdm ? int'({ch[CH_W-1:1], 1'b0}) : 2;
        if (slots < 2)      slots = 2;
        if (slots > MAX_CH) slots = MAX_CH;
        width = (wide || dsize != 2'd0) ? SLOT_MAX : 16;
        return slots * width;
    endfunction
endpackage

// File: rtl/aclk_shadow.sv
// Configuration shadow: tracks the live configuration while the block is
// idle and freezes it while running. Assumes enable is synchronous to clk.
module aclk_shadow
    import aclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  shadow_t live,
    output shadow_t held
);
    // Capture the live configuration only while not running.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (!enable) held <= live;
    end
endmodule

// File: rtl/aclk_prescaler.sv
// Bit-clock prescaler: counts master ticks within one bit period, starting
// each period with a fall; low for ceil(n/2) ticks, high for floor(n/2).
// Divide 1 produces both edges on every tick. Assumes tick is zero when n=0.
module aclk_prescaler #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    input  logic [DIV_W-1:0] div_live,
    output logic             fall_ev,
    output logic             lvl,
    output logic             rise_q,
    output logic             fall_q
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] last_pos;
    logic [DIV_W-1:0] hi_pos;
    logic             pass;
    logic             wrap;
    logic             rise_ev;

    // Phase boundaries of the current divide value.
    always_comb begin
        last_pos = div - DIV_W'(1);
        hi_pos   = div - (div >> 1);
        pass     = (div == DIV_W'(1));
        wrap     = (pcnt == last_pos);
        fall_ev  = tick & wrap;
        rise_ev  = tick & (pass | (!wrap && DIV_W'(pcnt + 1'b1) == hi_pos));
    end

    // Advance the phase counter, bit-clock level and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt   <= '0;
            lvl    <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else if (!run) begin
            pcnt   <= div_live - DIV_W'(1);
            lvl    <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= rise_ev;
            fall_q <= fall_ev;
            if (tick) pcnt <= wrap ? '0 : DIV_W'(pcnt + 1'b1);
            if (pass)         lvl <= tick;
            else if (rise_ev) lvl <= 1'b1;
            else if (fall_ev) lvl <= 1'b0;
        end
    end
endmodule

// File: rtl/aclk_framer.sv
// Frame counter: counts bit periods on each bit-clock fall, raises the
// internal frame level for the first half of the frame and strobes frame
// start at bit 0. Assumes flast + 1 is even.
module aclk_framer #(
    parameter int FCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall_ev,
    input  logic [FCNT_W-1:0] flast,
    input  logic [FCNT_W-1:0] half,
    input  logic [FCNT_W-1:0] flast_live,
    output logic              lvl,
    output logic              start_q
);
    logic [FCNT_W-1:0] bcnt;
    logic [FCNT_W-1:0] nxt;

    // Next bit index within the frame.
    always_comb nxt = (bcnt == flast) ? '0 : FCNT_W'(bcnt + 1'b1);

    // Step the bit index and frame level on each bit-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= '0;
            lvl     <= 1'b0;
            start_q <= 1'b0;
        end else if (!run) begin
            bcnt    <= flast_live;
            lvl     <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= fall_ev && (nxt == '0);
            if (fall_ev) begin
                bcnt <= nxt;
                lvl  <= (nxt < half);
            end
        end
    end
endmodule

// File: rtl/aclk_gen.sv
// Audio bit/frame clock generator (master mode). Derives bit clock and frame
// clock from one-cycle master ticks. Assumes all inputs are synchronous to clk.
module aclk_gen
    import aclk_pkg::*;
#(
    parameter int DIV_BITS = DIV_W,
    parameter int CHN_BITS = CH_W,
    parameter int FRM_BITS = FCNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mclk_en,
    input  logic                enable,
    input  logic                gate_off,
    input  logic [DIV_BITS-1:0] div_cfg,
    input  logic                inv_bclk_cfg,
    input  logic                inv_fclk_cfg,
    input  logic                rise_edge_cfg,
    input  logic                tdm_cfg,
    input  logic [CHN_BITS-1:0] chans_cfg,
    input  logic                wide_slot_cfg,
    input  logic [1:0]          dsize_cfg,
    output logic                bclk,
    output logic                bclk_rise,
    output logic                bclk_fall,
    output logic                fclk,
    output logic                frame_start
);
    shadow_t             live_cfg;
    shadow_t             run_cfg;
    logic [DIV_BITS-1:0] div_run;
    logic                tick;
    logic                fall_ev;
    logic                bit_lvl;
    logic                frm_lvl;
    int                  fbits;

    // Assemble the live configuration including the derived frame length.
    always_comb begin
        fbits          = frame_bits(tdm_cfg, chans_cfg, wide_slot_cfg, dsize_cfg);
        live_cfg.div   = div_cfg;
        live_cfg.inv_b = inv_bclk_cfg;
        live_cfg.inv_f = inv_fclk_cfg;
        live_cfg.rise_edge = rise_edge_cfg;
        live_cfg.flast = FRM_BITS'(fbits - 1);
        live_cfg.half  = FRM_BITS'(fbits / 2);
    end

    aclk_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .live   (live_cfg),
        .held   (run_cfg)
    );

    assign div_run = run_cfg.div;
    assign tick    = mclk_en & enable & ~gate_off & (div_run != '0);

    aclk_prescaler #(.DIV_W(DIV_BITS)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .tick     (tick),
        .div      (div_run),
        .div_live (div_cfg),
        .fall_ev  (fall_ev),
        .lvl      (bit_lvl),
        .rise_q   (bclk_rise),
        .fall_q   (bclk_fall)
    );

    aclk_framer #(.FCNT_W(FRM_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .fall_ev    (fall_ev),
        .flast      (run_cfg.flast),
        .half       (run_cfg.half),
        .flast_live (live_cfg.flast),
        .lvl        (frm_lvl),
        .start_q    (frame_start)
    );

    // Pad polarity: gate forces the inactive level, then optional inversion.
    assign bclk = (bit_lvl & ~gate_off) ^ run_cfg.inv_b;
    assign fclk = frm_lvl ^ ~run_cfg.rise_edge ^ run_cfg.inv_f;
endmodule

// File: rtl/aclk_gen_chk.sv
// Temporal checks on the clock generator, attached by bind.
module aclk_gen_chk #(
    parameter int DIV_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                gate_off,
    input logic                bclk_rise,
    input logic                bclk_fall,
    input logic                frame_start,
    input logic                fclk,
    input logic [DIV_BITS-1:0] div_run
);
    p_start_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bclk_fall);

    p_fclk_moves_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !bclk_fall) |-> $stable(fclk));

    p_gate_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_off) |-> (!bclk_rise && !bclk_fall));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!bclk_rise && !bclk_fall && !frame_start));

    p_zero_div_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_run) == '0) |-> (!bclk_rise && !bclk_fall));
endmodule

bind aclk_gen aclk_gen_chk #(.DIV_BITS(DIV_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .gate_off    (gate_off),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .frame_start (frame_start),
    .fclk        (fclk),
    .div_run     (div_run)
);

// File: tb/tb_aclk_gen.sv
`timescale 1ns/1ps
module tb_aclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk_en = 1'b0;
    logic       enable = 1'b0;
    logic       gate_off = 1'b0;
    logic [8:0] div_cfg = '0;
    logic       inv_bclk_cfg = 1'b0;
    logic       inv_fclk_cfg = 1'b0;
    logic       rise_edge_cfg = 1'b0;
    logic       tdm_cfg = 1'b0;
    logic [4:0] chans_cfg = '0;
    logic       wide_slot_cfg = 1'b0;
    logic [1:0] dsize_cfg = '0;
    logic       bclk, bclk_rise, bclk_fall, fclk, frame_start;

    aclk_gen dut (.*);

    always #5 clk = ~clk;

    typedef struct { int cyc; int kind; logic val; } ev_t;
    ev_t   evq[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    tracking = 1'b0;
    int    track_end = 0;
    bit    gen_on = 1'b0;
    int    e0 = 0;
    int    per_n = 1;
    string cur_tag = "";
    logic  prev_fclk = 1'b0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Master tick generator: one tick every per_n cycles from edge e0.
    initial forever begin
        @(posedge clk); #2;
        mclk_en = gen_on && (((cyc + 1 - e0) % per_n) == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Monitor: compare observed edge events with the scoreboard queue.
    always @(negedge clk) begin
        logic [3:0] obs;
        logic [3:0] expm;
        logic [3:0] vals;
        ev_t e;
        obs = {fclk != prev_fclk, frame_start, bclk_rise, bclk_fall};
        prev_fclk = fclk;
        if (tracking && cyc <= track_end) begin
            expm = '0;
            vals = '0;
            while (evq.size() > 0 && evq[0].cyc < cyc) begin
                e = evq.pop_front();
                check(1'b0, {"R2/R8 missed event ", cur_tag}, e.kind, e.cyc);
            end
            while (evq.size() > 0 && evq[0].cyc == cyc) begin
                e = evq.pop_front();
                expm[e.kind] = 1'b1;
                vals[e.kind] = e.val;
            end
            for (int k = 0; k < 4; k++) begin
                if (obs[k] || expm[k]) begin
                    if (obs[k] != expm[k])
                        check(1'b0, $sformatf("%s kind %0d cyc %0d %s", (k < 2) ? "R2" : "R8", k, cyc, cur_tag),
                              obs[k], expm[k]);
                    else if (k < 2)
                        check(bclk == vals[k], {"R9 bclk level ", cur_tag}, bclk, vals[k]);
                    else if (k == 3)
                        check(fclk == vals[k], {"R9 fclk level ", cur_tag}, fclk, vals[k]);
                    else
                        check(1'b1, {"R12 frame start ", cur_tag}, 1, 1);
                end
            end
        end
    end

    // Driver: configure, enable, and push the expected edge schedule.
    task automatic run_case(input int div, input int p, input int nb, input bit tdm,
                            input logic [4:0] ch, input bit wide, input logic [1:0] ds,
                            input bit ib, input bit inf, input bit re, input int chg,
                            input string tag);
        int slots, width, frame, lo;
        ev_t e;
        @(posedge clk); #1;
        enable = 0; gen_on = 0;
        div_cfg = 9'(div); per_n = p; tdm_cfg = tdm; chans_cfg = ch;
        wide_slot_cfg = wide; dsize_cfg = ds; inv_bclk_cfg = ib;
        inv_fclk_cfg = inf; rise_edge_cfg = re; cur_tag = tag;
        repeat (3) @(posedge clk);
        #1;
        // R6/R7 frame length from the requirement rules.
        slots = tdm ? int'({ch[4:1], 1'b0}) : 2;
        if (slots < 2) slots = 2;
        if (slots > 16) slots = 16;
        width = (wide || ds != 2'd0) ? 32 : 16;
        frame = slots * width;
        lo = div - div / 2;
        e0 = cyc + 1;
        for (int m = 0; m < nb; m++) begin
            e.cyc = e0 + p * m * div;
            e.kind = 0; e.val = (div == 1) ? ~ib : ib; evq.push_back(e);
            if (div == 1) begin
                e.kind = 1; e.val = ~ib; evq.push_back(e);
            end
            if (m % frame == 0) begin
                e.kind = 2; e.val = 1'b1; evq.push_back(e);
            end
            if (m % frame == 0 || m % frame == frame / 2) begin
                e.kind = 3;
                e.val = ((m % frame == 0) ? 1'b1 : 1'b0) ^ ~re ^ inf;
                evq.push_back(e);
            end
            if (div >= 2) begin
                e.cyc = e0 + p * (m * div + lo);
                e.kind = 1; e.val = ~ib; evq.push_back(e);
            end
        end
        track_end = e0 + p * nb * div - 1;
        tracking = 1; enable = 1; gen_on = 1;
        if (chg > 0) begin
            repeat (chg) @(posedge clk);
            #1;
            div_cfg = 9'd7;          // R11: live changes must be ignored
            inv_fclk_cfg = ~inf;
        end
        while (cyc <= track_end) begin
            @(posedge clk); #1;
        end
        tracking = 0;
        check(evq.size() == 0, {"R2 leftover events ", tag}, evq.size(), 0);
        evq.delete();
        enable = 0; gen_on = 0;
    endtask

    initial begin
        bit seen;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        check(bclk == 1'b0, "R1 bclk in reset", bclk, 0);
        check(fclk == 1'b1, "R1 fclk in reset", fclk, 1);
        rst_n = 1;
        repeat (3) @(posedge clk);
        #1;
        check(bclk == 1'b0 && fclk == 1'b1, "R1 idle levels", {bclk, fclk}, 1);
        check(!bclk_rise && !bclk_fall && !frame_start, "R1 idle strobes",
              {bclk_rise, bclk_fall, frame_start}, 0);

        // R2 R6 R7 R8 R12: even divide, two-slot 16-bit frame
        run_case(4, 1, 70, 1'b0, 5'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 0, "caseA");
        // R2 odd divide, R5 sparse ticks, R7 wide slot
        run_case(3, 3, 70, 1'b0, 5'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 0, "caseB");
        // R3 pass-through, R6 bit0 ignored (5 -> 4), R7 24-bit forces 32, R9 rising + bclk invert
        run_case(1, 1, 260, 1'b1, 5'd5, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 0, "caseC");
        // R6 clamp to 16 slots, R9 fclk invert, R11 live change ignored
        run_case(2, 1, 260, 1'b1, 5'd30, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 37, "caseD");

        // R4: divide 0 stops the clock
        @(posedge clk); #1;
        div_cfg = 9'd0; inv_bclk_cfg = 1'b1; per_n = 1;
        repeat (3) @(posedge clk);
        #1;
        e0 = cyc + 1; enable = 1; gen_on = 1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            check(!bclk_rise && !bclk_fall && bclk == 1'b1, "R4 stopped clock",
                  {bclk_rise, bclk_fall, bclk}, 1);
        end
        enable = 0; gen_on = 0;

        // R10: gate holds the bit clock inactive, then resumes
        @(posedge clk); #1;
        div_cfg = 9'd2; inv_bclk_cfg = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        e0 = cyc + 1; enable = 1; gen_on = 1;
        repeat (21) @(posedge clk);
        #1;
        gate_off = 1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            check(!bclk_rise && !bclk_fall && bclk == 1'b1, "R10 gated",
                  {bclk_rise, bclk_fall, bclk}, 1);
        end
        gate_off = 0;
        seen = 0;
        repeat (6) begin
            @(posedge clk); #1;
            if (bclk_rise || bclk_fall) seen = 1;
        end
        check(seen, "R10 resume after gate", seen, 1);
        enable = 0; gen_on = 0;
        repeat (3) @(posedge clk);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule